// File: doc/BRIEF.md
# Pipelined chunked integer multiplier

This block multiplies two unsigned operands and returns the low half of their product. A new operand pair may enter every clock together with a start strobe. The pair then moves through a chain of identical stages. Each stage takes the lowest slice of the multiplier it receives and multiplies it by the full multiplicand. It adds that partial product to the running sum and passes on the multiplier shifted down by one slice and the multiplicand shifted up by one slice. A done flag travels with each operation, so the result appears at the output of the last stage, qualified by that flag, a fixed number of clocks after the strobe.

The number of stages is a parameter and must divide the operand width. More stages give a narrower slice multiplier and a shorter path in each stage, at the cost of latency and pipeline registers. Signed operands, the upper half of the product and any form of stall are not provided. The pipeline always advances.

Top module: `chunk_mult_top`

## Requirements
- R1: When `done_o` is high, `prod_o` equals bits OPW-1..0 of `op_a_i * op_b_i`, taken as unsigned numbers, for the pair that entered with the matching start.
- R2: `done_o` is high in the cycle after the NSTG-th rising edge, counting as the first edge the one that sampled `start_i` high.
- R3: A new pair may be presented on every clock with `start_i` high. Results come out back to back, one per clock, in the order the pairs entered.
- R4: Product bits above OPW-1 are discarded. For example, all-ones times all-ones gives 1, and 2^63 times 2 gives 0 at OPW = 64.
- R5: `done_o` is low in every cycle whose matching start cycle had `start_i` low, so idle gaps in the input stream appear as gaps in the output.
- R6: `rst` is synchronous and active high. A rising edge with `rst` high clears every done flag, which drops all operations in flight. A start sampled together with `rst` produces no result. `done_o` stays low for at least NSTG cycles after reset. The product datapath is not reset.
- R7: NSTG must divide OPW. Each stage consumes OPW/NSTG multiplier bits, lowest slice first. A stage whose slice is zero passes its running sum on unchanged. Results and their order are the same for NSTG = 1, 2, 4 and 8, with latency NSTG.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the done chain |
| start_i | input | 1 | Marks a valid operand pair on this clock |
| op_a_i | input | OPW | Multiplicand |
| op_b_i | input | OPW | Multiplier, consumed one slice per stage |
| done_o | output | 1 | Result valid on `prod_o` |
| prod_o | output | OPW | Low OPW bits of the product |

## Verification
The assertions check on every cycle that each stage's flag follows its input by one clock and never appears without one. They also check that reset clears the flags and that no done can appear in the first NSTG cycles after reset. Further assertions check that a stage with a zero slice or a zero multiplicand adds nothing to the running sum. Only the bench scenarios can show the actual product values: the wrap-around cases, the ordering of back-to-back results, operations dropped by a reset in flight, and the same results at depths 1, 2, 4 and 8.

// File: rtl/chunk_mult_pkg.sv
package chunk_mult_pkg;
  localparam int DEF_OPW  = 64;
  localparam int DEF_NSTG = 8;

  function automatic int slice_width(input int opw, input int nstg);
    return opw / nstg;
  endfunction
endpackage

// File: rtl/chunk_mult_slice.sv
// Partial product of one multiplier slice against the full multiplicand,
// truncated to the operand width.
module chunk_mult_slice #(
  parameter int OPW = 64,
  parameter int SLW = 8
) (
  input  logic [SLW-1:0] chunk_i,
  input  logic [OPW-1:0] mcnd_i,
  output logic [OPW-1:0] pp_o
);
  logic [OPW-1:0] chunk_ext;

  generate
    if (SLW == OPW) begin : g_full
      assign chunk_ext = chunk_i;
    end else begin : g_part
      assign chunk_ext = {{(OPW-SLW){1'b0}}, chunk_i};
    end
  endgenerate

  assign pp_o = chunk_ext * mcnd_i;
endmodule

// File: rtl/chunk_mult_stage.sv
// One pipeline step: registers the incoming sum and its own partial product
// apart, and adds them only on the way out.
module chunk_mult_stage #(
  parameter int OPW = 64,
  parameter int SLW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           vld_i,
  input  logic [OPW-1:0] acc_i,
  input  logic [OPW-1:0] mplr_i,
  input  logic [OPW-1:0] mcnd_i,
  output logic           vld_o,
  output logic [OPW-1:0] acc_o,
  output logic [OPW-1:0] mplr_o,
  output logic [OPW-1:0] mcnd_o
);
  logic [OPW-1:0] pp_d;
  logic [OPW-1:0] sum_q;
  logic [OPW-1:0] pp_q;
  logic [OPW-1:0] mplr_q;
  logic [OPW-1:0] mcnd_q;
  logic           vld_q;

  chunk_mult_slice #(.OPW(OPW), .SLW(SLW)) u_slice (
    .chunk_i (mplr_i[SLW-1:0]),
    .mcnd_i  (mcnd_i),
    .pp_o    (pp_d)
  );

  // Datapath registers carry no reset.
  always_ff @(posedge clk) begin
    sum_q  <= acc_i;
    pp_q   <= pp_d;
    mplr_q <= mplr_i >> SLW;
    mcnd_q <= mcnd_i << SLW;
  end

  always_ff @(posedge clk) begin
    if (rst) vld_q <= 1'b0;
    else     vld_q <= vld_i;
  end

  assign acc_o  = sum_q + pp_q;
  assign mplr_o = mplr_q;
  assign mcnd_o = mcnd_q;
  assign vld_o  = vld_q;

  p_token_advance_r2: assert property (@(posedge clk) disable iff (rst)
    vld_i |=> vld_o);
  p_no_phantom_r5: assert property (@(posedge clk) disable iff (rst)
    !vld_i |=> !vld_o);
  p_reset_clears_r6: assert property (@(posedge clk)
    rst |=> !vld_o);
  p_zero_slice_r7: assert property (@(posedge clk) disable iff (rst)
    (mplr_i[SLW-1:0] == '0) |=> (acc_o == $past(acc_i)));
  p_zero_mcnd_r1: assert property (@(posedge clk) disable iff (rst)
    (mcnd_i == '0) |=> (acc_o == $past(acc_i)));
endmodule

// File: rtl/chunk_mult_top.sv
module chunk_mult_top
  import chunk_mult_pkg::*;
#(
  parameter int OPW  = DEF_OPW,
  parameter int NSTG = DEF_NSTG
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start_i,
  input  logic [OPW-1:0] op_a_i,
  input  logic [OPW-1:0] op_b_i,
  output logic           done_o,
  output logic [OPW-1:0] prod_o
);
  localparam int SLW = slice_width(OPW, NSTG);
  localparam int CW  = $clog2(NSTG + 1);

  generate
    if ((OPW % NSTG) != 0) begin : g_bad_depth
      $error("NSTG must divide OPW");
    end
  endgenerate

  logic [NSTG:0][OPW-1:0] acc_w;
  logic [NSTG:0][OPW-1:0] mplr_w;
  logic [NSTG:0][OPW-1:0] mcnd_w;
  logic [NSTG:0]          vld_w;

  assign acc_w[0]  = '0;
  assign mplr_w[0] = op_b_i;
  assign mcnd_w[0] = op_a_i;
  assign vld_w[0]  = start_i;

  generate
    for (genvar s = 0; s < NSTG; s++) begin : g_stage
      chunk_mult_stage #(.OPW(OPW), .SLW(SLW)) u_stage (
        .clk    (clk),
        .rst    (rst),
        .vld_i  (vld_w[s]),
        .acc_i  (acc_w[s]),
        .mplr_i (mplr_w[s]),
        .mcnd_i (mcnd_w[s]),
        .vld_o  (vld_w[s+1]),
        .acc_o  (acc_w[s+1]),
        .mplr_o (mplr_w[s+1]),
        .mcnd_o (mcnd_w[s+1])
      );
    end
  endgenerate

  // Operands shifted out of the last stage have no consumer.
  logic unused_tail;
  assign unused_tail = ^{mplr_w[NSTG], mcnd_w[NSTG]};

  assign done_o = vld_w[NSTG];
  assign prod_o = acc_w[NSTG];

  // Cycles since reset, saturating at the depth; used only by the check below.
  logic [CW-1:0] quiet_cnt;
  always_ff @(posedge clk) begin
    if (rst)                          quiet_cnt <= '0;
    else if (quiet_cnt != CW'(NSTG))  quiet_cnt <= quiet_cnt + 1'b1;
  end

  p_quiet_after_reset_r6: assert property (@(posedge clk) disable iff (rst)
    (quiet_cnt < CW'(NSTG)) |-> !done_o);
endmodule

// File: tb/chunk_mult_top_bench.sv
module chunk_mult_top_bench;
  localparam int W = 64;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start_i = 1'b0;
  logic [W-1:0] op_a_i = '0;
  logic [W-1:0] op_b_i = '0;
  logic         done_v [4];
  logic [W-1:0] prod_v [4];

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  logic         st_h [256];
  logic         rs_h [256];
  logic [W-1:0] ex_h [256];
  string        tg_h [256];

  always #4 clk = ~clk;   // 125 MHz

  always @(posedge clk) cyc <= cyc + 1;

  // Index 3 is the default depth 8; indices 0..2 are depths 1, 2, 4.
  chunk_mult_top #(.OPW(W), .NSTG(8)) u_chunk_mult (
    .clk(clk), .rst(rst), .start_i(start_i), .op_a_i(op_a_i), .op_b_i(op_b_i),
    .done_o(done_v[3]), .prod_o(prod_v[3])
  );

  generate
    for (genvar g = 0; g < 3; g++) begin : g_alt
      chunk_mult_top #(.OPW(W), .NSTG(1 << g)) u_alt (
        .clk(clk), .rst(rst), .start_i(start_i), .op_a_i(op_a_i), .op_b_i(op_b_i),
        .done_o(done_v[g]), .prod_o(prod_v[g])
      );
    end
  endgenerate

  // {multiplicand, multiplier, expected low product}
  localparam logic [3*W-1:0] VEC [14] = '{
    {64'h0, 64'h1234_5678_9ABC_DEF0, 64'h0},
    {64'h1, 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0},
    {64'h3, 64'h5, 64'hF},
    {64'hFF, 64'hFF, 64'hFE01},
    {64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1},
    {64'hFFFF_FFFF_FFFF_FFFF, 64'h2, 64'hFFFF_FFFF_FFFF_FFFE},
    {64'h7, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFF9},
    {64'h8000_0000_0000_0000, 64'h2, 64'h0},
    {64'h1_0000_0000, 64'h1_0000_0000, 64'h0},
    {64'hFFFF_FFFF, 64'hFFFF_FFFF, 64'hFFFF_FFFE_0000_0001},
    {64'h8000_0000_0000_0001, 64'h8000_0000_0000_0001, 64'h1},
    {64'h1_0000_0001, 64'h1_0000_0001, 64'h2_0000_0001},
    {64'h3, 64'h100_0000_0000, 64'h300_0000_0000},
    {64'h8000_0000_0000_0000, 64'h1, 64'h8000_0000_0000_0000}
  };

  // Present one clock of input and record what must come out of it.
  task automatic apply(input bit s, input logic [W-1:0] a, input logic [W-1:0] b,
                       input bit r, input logic [W-1:0] e, input string t);
    int idx;
    idx = (cyc + 1) & 255;
    start_i = s;
    op_a_i = a;
    op_b_i = b;
    rst = r;
    st_h[idx] = s;
    rs_h[idx] = r;
    ex_h[idx] = e;
    tg_h[idx] = t;
    @(posedge clk);
    #2;
  endtask

  task automatic mul(input bit s, input logic [W-1:0] a, input logic [W-1:0] b,
                     input string t);
    logic [2*W-1:0] wide;
    wide = {{W{1'b0}}, a} * {{W{1'b0}}, b};
    apply(s, a, b, 1'b0, wide[W-1:0], t);
  endtask

  function automatic logic [W-1:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  // Checker: at the negedge after edge c, depth L shows the token sampled at c-L+1.
  always @(negedge clk) begin
    if (cyc >= 1) begin
      for (int i = 0; i < 4; i++) begin
        int  L;
        int  k;
        bit  kill;
        bit  exp_d;
        string t;
        L = 1 << i;
        k = cyc - L + 1;
        kill = 1'b0;
        exp_d = 1'b0;
        if (k >= 1) begin
          for (int j = 0; j < L; j++) if (rs_h[(k + j) & 255]) kill = 1'b1;
          exp_d = st_h[k & 255] && !kill;
        end else begin
          kill = 1'b1;
        end
        if (i != 3)      t = "R7";
        else if (kill)   t = "R6";
        else if (exp_d)  t = "R2";
        else             t = "R5";
        n_chk++;
        if (done_v[i] !== exp_d) begin
          n_bad++;
          $display("FAIL %s depth %0d cycle %0d: done=%0b expected %0b",
                   t, L, cyc, done_v[i], exp_d);
        end
        if (exp_d) begin
          t = (i != 3) ? "R7" : tg_h[k & 255];
          n_chk++;
          if (prod_v[i] !== ex_h[k & 255]) begin
            n_bad++;
            $display("FAIL %s depth %0d cycle %0d: prod=%h expected %h",
                     t, L, cyc, prod_v[i], ex_h[k & 255]);
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired: cycle %0d expected completion", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R6: reset state, including starts offered during reset
    for (int i = 0; i < 4; i++) apply(i[0], rnd64(), rnd64(), 1'b1, '0, "R6");

    // R1 / R4: table of hand-computed vectors, back to back
    for (int i = 0; i < 14; i++) begin
      logic [2*W-1:0] wide;
      wide = {{W{1'b0}}, VEC[i][3*W-1:2*W]} * {{W{1'b0}}, VEC[i][2*W-1:W]};
      apply(1'b1, VEC[i][3*W-1:2*W], VEC[i][2*W-1:W], 1'b0, VEC[i][W-1:0],
            (wide[2*W-1:W] != '0) ? "R4" : "R1");
    end

    // R4: powers of two against random operands
    for (int i = 0; i < 32; i++) mul(1'b1, 64'h1 << ($urandom % 64), rnd64(), "R4");

    // R3: long back-to-back random stream
    for (int i = 0; i < 200; i++) mul(1'b1, rnd64(), rnd64(), "R3");

    // R5: streams with idle gaps
    for (int i = 0; i < 80; i++) mul($urandom % 2 == 0, rnd64(), rnd64(), "R5");
    for (int i = 0; i < 12; i++) mul(1'b0, rnd64(), rnd64(), "R5");

    // R6: reset while operations are in flight, then resume
    for (int i = 0; i < 5; i++) mul(1'b1, rnd64(), rnd64(), "R3");
    apply(1'b1, rnd64(), rnd64(), 1'b1, '0, "R6");
    apply(1'b1, rnd64(), rnd64(), 1'b1, '0, "R6");
    for (int i = 0; i < 20; i++) mul(1'b1, rnd64(), rnd64(), "R6");

    // R7: operands with zero multiplier slices
    for (int i = 0; i < 16; i++) mul(1'b1, rnd64(), rnd64() & 64'hFF00_00FF_0000_FF00, "R7");

    for (int i = 0; i < 12; i++) mul(1'b0, '0, '0, "R5");
    #1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule